// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is an up-counting timer that sits on a simple register bus. A programmable divider turns the input clock into count ticks, one tick every (divide + 1) clock cycles, and the counter climbs on each tick while the run bit is set. When the counter sits at the programmed limit and a tick arrives, it returns to zero and raises an update event. If the update interrupt is enabled, that event latches a status flag and produces a one-cycle interrupt pulse.

Software drives the timer with single-cycle register writes and reads the registers back through a combinational read port. The count can be loaded directly or forced to zero by a software event. The divider can be changed on the fly without losing the count. A group of mode, compare and option registers is kept as plain read/write storage for software and has no effect on counting.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset every register reads zero: control, interrupt enable, status, event, count, divide, limit, both mode registers, the four compare registers and the option register.
- R2: While control bit 0 (run) is set, the count rises by one every (divide + 1) clock cycles. While run is clear, the count holds its value.
- R3: With a nonzero limit, a tick that finds the count equal to the limit sets the count to 0 and raises an update event.
- R4: An update event sets status bit 0 and drives `irq` high for exactly that one event cycle, but only when interrupt-enable bit 0 is set. With that bit clear, an update event changes neither status nor `irq`.
- R5: While the limit is zero, no update event occurs. The counter keeps advancing and wraps at its natural width.
- R6: A write to status (0x10) ANDs the written data into the flags. A 0 in bit 0 clears the flag and a 1 leaves it as it was. A flag set by an event in the same cycle takes precedence.
- R7: A write to the event register (0x14) with bit 0 set loads the count with 0 and restarts the divider phase. The event register always reads 0.
- R8: A write to the count register (0x24) loads the written value as the new count. The write takes precedence over a tick in the same cycle.
- R9: A write to the divide register (0x28) leaves the count unchanged. Only the rate of later ticks follows the new value.
- R10: The register offsets are control 0x00, interrupt enable 0x0C, status 0x10, event 0x14, mode A 0x18, mode B 0x1C, count 0x24, divide 0x28, limit 0x2C, compare 0 to 3 at 0x34, 0x38, 0x3C and 0x40, and option 0x50. The mode, compare and option registers hold any written value and read it back.
- R11: An offset not listed in R10 reads as zero, and a write to it changes no register and no count.
- R12: Reading the count register returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq | output | 1 | One-cycle update interrupt pulse |

## Verification
The hardest situations to reach are the collisions between a bus write and a running tick: a count load or a zero-forcing event that lands on the same edge as a tick. The bench reaches them by starting the counter from a known phase, which it sets with an event write while stopped. It then counts exact negative edges before it issues the write mid-run, so the write and the tick fall on a known edge and the resulting count has one correct value. The bench also checks the interrupt period with limit 4 and divide 0. It counts pulses over a fixed window and compares the total with window / (limit + 1).

// File: rtl/prt_pkg.sv
package prt_pkg;

    // Byte offsets of the register map
    localparam int unsigned OFF_CTRL   = 'h00;
    localparam int unsigned OFF_IEN    = 'h0C;
    localparam int unsigned OFF_STAT   = 'h10;
    localparam int unsigned OFF_EVT    = 'h14;
    localparam int unsigned OFF_MODE_A = 'h18;
    localparam int unsigned OFF_MODE_B = 'h1C;
    localparam int unsigned OFF_COUNT  = 'h24;
    localparam int unsigned OFF_DIV    = 'h28;
    localparam int unsigned OFF_LIMIT  = 'h2C;
    localparam int unsigned OFF_CMP0   = 'h34;
    localparam int unsigned OFF_OPT    = 'h50;

    // Bit positions inside the registers
    localparam int unsigned RUN_BIT  = 0;
    localparam int unsigned UIEN_BIT = 0;
    localparam int unsigned UFLG_BIT = 0;
    localparam int unsigned UGEN_BIT = 0;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_IEN,
        SEL_STAT,
        SEL_EVT,
        SEL_MODE_A,
        SEL_MODE_B,
        SEL_COUNT,
        SEL_DIV,
        SEL_LIMIT,
        SEL_CMP,
        SEL_OPT
    } reg_sel_e;

endpackage

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] divide,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } div_state_t;

    div_state_t st_d, st_q;

    // A tick fires once the phase has reached the divide value. Using >=
    // lets a smaller divide written mid-period take effect at once.
    assign tick = run && (st_q.phase >= divide);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.phase = '0;
        end else if (tick) begin
            st_d.phase = '0;
        end else if (run) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic limit_live;

    assign limit_live = (limit != '0);
    // A bus load owns the edge, so it suppresses the wrap event.
    assign wrap  = tick && limit_live && (st_q.value == limit) && !load_en;
    assign count = st_q.value;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.value = load_val;
        end else if (wrap) begin
            st_d.value = '0;
        end else if (tick) begin
            st_d.value = st_q.value + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: without a tick or a load the count does not move
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(load_en)) |-> $stable(count));

    // R3: a wrap event leaves the counter at zero
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap) |-> (count == '0));

endmodule

// File: rtl/prt_regs.sv
module prt_regs
    import prt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 16,
    parameter int N_CMP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              upd_evt,
    input  logic [CNT_W-1:0]  count,
    output logic              run,
    output logic [DIV_W-1:0]  divide,
    output logic [CNT_W-1:0]  limit,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_load_val,
    output logic              div_restart,
    output logic              irq
);

    localparam int CMP_IDX_W = (N_CMP > 1) ? $clog2(N_CMP) : 1;

    typedef struct packed {
        logic [DATA_W-1:0]            ctrl;
        logic [DATA_W-1:0]            ien;
        logic [DATA_W-1:0]            mode_a;
        logic [DATA_W-1:0]            mode_b;
        logic [DATA_W-1:0]            option;
        logic [N_CMP-1:0][DATA_W-1:0] cmp;
        logic [DIV_W-1:0]             divide;
        logic [CNT_W-1:0]             limit;
        logic                         flag;
        logic                         irq;
    } reg_state_t;

    reg_state_t st_d, st_q;

    reg_sel_e             sel;
    logic [CMP_IDX_W-1:0] cmp_idx;
    logic [N_CMP-1:0]     cmp_hit;
    logic                 wr_evt_gen;
    logic                 upd_taken;

    // Address decode for the compare bank, one comparator per channel
    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp_dec
        localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(OFF_CMP0 + 4 * g);
        assign cmp_hit[g] = (bus_addr == CMP_ADDR);
    end

    always_comb begin
        sel     = SEL_NONE;
        cmp_idx = '0;
        if (bus_addr == ADDR_W'(OFF_CTRL))        sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFF_IEN))    sel = SEL_IEN;
        else if (bus_addr == ADDR_W'(OFF_STAT))   sel = SEL_STAT;
        else if (bus_addr == ADDR_W'(OFF_EVT))    sel = SEL_EVT;
        else if (bus_addr == ADDR_W'(OFF_MODE_A)) sel = SEL_MODE_A;
        else if (bus_addr == ADDR_W'(OFF_MODE_B)) sel = SEL_MODE_B;
        else if (bus_addr == ADDR_W'(OFF_COUNT))  sel = SEL_COUNT;
        else if (bus_addr == ADDR_W'(OFF_DIV))    sel = SEL_DIV;
        else if (bus_addr == ADDR_W'(OFF_LIMIT))  sel = SEL_LIMIT;
        else if (bus_addr == ADDR_W'(OFF_OPT))    sel = SEL_OPT;
        else begin
            for (int i = 0; i < N_CMP; i++) begin
                if (cmp_hit[i]) begin
                    sel     = SEL_CMP;
                    cmp_idx = CMP_IDX_W'(i);
                end
            end
        end
    end

    assign wr_evt_gen = bus_we && (sel == SEL_EVT) && bus_wdata[UGEN_BIT];
    assign upd_taken  = upd_evt && st_q.ien[UIEN_BIT];

    // Side effects towards the counter and the divider
    always_comb begin
        cnt_load     = 1'b0;
        cnt_load_val = '0;
        div_restart  = 1'b0;
        if (bus_we && (sel == SEL_COUNT)) begin
            cnt_load     = 1'b1;
            cnt_load_val = bus_wdata[CNT_W-1:0];
        end else if (wr_evt_gen) begin
            cnt_load     = 1'b1;
            cnt_load_val = '0;
            div_restart  = 1'b1;
        end
    end

    // Next-state logic for the stored registers
    always_comb begin
        st_d     = st_q;
        st_d.irq = upd_taken;
        if (bus_we) begin
            case (sel)
                SEL_CTRL:   st_d.ctrl   = bus_wdata;
                SEL_IEN:    st_d.ien    = bus_wdata;
                SEL_STAT:   st_d.flag   = st_q.flag & bus_wdata[UFLG_BIT];
                SEL_MODE_A: st_d.mode_a = bus_wdata;
                SEL_MODE_B: st_d.mode_b = bus_wdata;
                SEL_DIV:    st_d.divide = bus_wdata[DIV_W-1:0];
                SEL_LIMIT:  st_d.limit  = bus_wdata[CNT_W-1:0];
                SEL_OPT:    st_d.option = bus_wdata;
                SEL_CMP:    st_d.cmp[cmp_idx] = bus_wdata;
                default:    ;
            endcase
        end
        if (upd_taken) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read port, combinational on the address
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CTRL:   bus_rdata = st_q.ctrl;
            SEL_IEN:    bus_rdata = st_q.ien;
            SEL_STAT:   bus_rdata = DATA_W'(st_q.flag);
            SEL_EVT:    bus_rdata = '0;
            SEL_MODE_A: bus_rdata = st_q.mode_a;
            SEL_MODE_B: bus_rdata = st_q.mode_b;
            SEL_COUNT:  bus_rdata = DATA_W'(count);
            SEL_DIV:    bus_rdata = DATA_W'(st_q.divide);
            SEL_LIMIT:  bus_rdata = DATA_W'(st_q.limit);
            SEL_OPT:    bus_rdata = st_q.option;
            SEL_CMP:    bus_rdata = st_q.cmp[cmp_idx];
            default:    bus_rdata = '0;
        endcase
    end

    assign run    = st_q.ctrl[RUN_BIT];
    assign divide = st_q.divide;
    assign limit  = st_q.limit;
    assign irq    = st_q.irq;

    // R4: an interrupt pulse implies the flag was latched with it
    a_r4_flag_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.flag);

    // R4: an interrupt pulse needs the enable bit and a running counter
    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_q.ien[UIEN_BIT] && run));

    // R5: no interrupt can follow a cycle with a zero limit
    a_r5_no_event_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(limit) != '0));

    // R7: a software update-generate write leaves the counter at zero
    a_r7_evt_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_evt_gen) |-> (count == '0));

endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 16,
    parameter int N_CMP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic             run;
    logic [DIV_W-1:0] divide;
    logic [CNT_W-1:0] limit;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             div_restart;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;

    prt_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DIV_W  (DIV_W),
        .N_CMP  (N_CMP)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .upd_evt      (wrap),
        .count        (count),
        .run          (run),
        .divide       (divide),
        .limit        (limit),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .div_restart  (div_restart),
        .irq          (irq)
    );

    prt_prescaler #(
        .DIV_W (DIV_W)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (div_restart),
        .divide  (divide),
        .tick    (tick)
    );

    prt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_en  (cnt_load),
        .load_val (cnt_load_val),
        .limit    (limit),
        .count    (count),
        .wrap     (wrap)
    );

endmodule

// File: tb/prescaled_reload_timer_tb.sv
module prescaled_reload_timer_tb;

    localparam time CLK_PERIOD = 10ns;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_IEN   = 8'h0C;
    localparam logic [7:0] A_STAT  = 8'h10;
    localparam logic [7:0] A_EVT   = 8'h14;
    localparam logic [7:0] A_MODEA = 8'h18;
    localparam logic [7:0] A_MODEB = 8'h1C;
    localparam logic [7:0] A_COUNT = 8'h24;
    localparam logic [7:0] A_DIV   = 8'h28;
    localparam logic [7:0] A_LIMIT = 8'h2C;
    localparam logic [7:0] A_CMP0  = 8'h34;
    localparam logic [7:0] A_OPT   = 8'h50;
    localparam logic [7:0] A_HOLE  = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prescaled_reload_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle_count_irq(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            if (irq) pulses++;
        end
    endtask

    // Stop, set the rate and limit, zero the count and the divider phase
    task automatic setup(input int dv, input int lim, input int ien);
        wr(A_CTRL, 0);
        wr(A_DIV, dv);
        wr(A_LIMIT, lim);
        wr(A_IEN, ien);
        wr(A_EVT, 1);
        wr(A_STAT, 0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd(A_IEN, v);   check("R1 ien", v, 0);
        rd(A_STAT, v);  check("R1 status", v, 0);
        rd(A_EVT, v);   check("R1 event", v, 0);
        rd(A_COUNT, v); check("R1 count", v, 0);
        rd(A_DIV, v);   check("R1 divide", v, 0);
        rd(A_LIMIT, v); check("R1 limit", v, 0);
        rd(A_MODEA, v); check("R1 modeA", v, 0);
        rd(A_OPT, v);   check("R1 option", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_count_rate;
        logic [31:0] v;
        int p;
        setup(0, 100, 0);
        wr(A_CTRL, 1);
        idle_count_irq(10, p);
        rd(A_COUNT, v); check("R2 R12 divide0 count", v, 10);
        setup(3, 100, 0);
        wr(A_CTRL, 1);
        idle_count_irq(20, p);
        rd(A_COUNT, v); check("R2 divide3 count", v, 5);
    endtask

    task automatic t_wrap_irq;
        logic [31:0] v;
        int p;
        setup(0, 4, 1);
        wr(A_CTRL, 1);
        idle_count_irq(50, p);
        check("R3 R4 pulses in 50 cycles", p, 10);
        rd(A_STAT, v); check("R4 flag set", v, 1);
        rd(A_COUNT, v); check("R3 count after wrap", v, 0);
    endtask

    task automatic t_status_and;
        logic [31:0] v;
        wr(A_CTRL, 0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R6 write 1 keeps", v, 1);
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); check("R6 write 0 clears", v, 0);
    endtask

    task automatic t_irq_disabled;
        logic [31:0] v;
        int p;
        setup(0, 2, 0);
        wr(A_CTRL, 1);
        idle_count_irq(30, p);
        check("R4 no pulse when disabled", p, 0);
        rd(A_STAT, v); check("R4 no flag when disabled", v, 0);
        rd(A_COUNT, v); check("R3 wraps without enable", v, 0);
    endtask

    task automatic t_zero_limit;
        logic [31:0] v;
        int p;
        setup(0, 0, 1);
        wr(A_CTRL, 1);
        idle_count_irq(20, p);
        check("R5 no pulse zero limit", p, 0);
        rd(A_STAT, v); check("R5 no flag zero limit", v, 0);
        rd(A_COUNT, v); check("R5 free run", v, 20);
    endtask

    task automatic t_count_load;
        logic [31:0] v;
        int p;
        setup(0, 100, 0);
        wr(A_COUNT, 7);
        rd(A_COUNT, v); check("R8 loaded", v, 7);
        wr(A_CTRL, 1);
        idle_count_irq(3, p);
        rd(A_COUNT, v); check("R8 runs from load", v, 10);
        wr(A_COUNT, 40);
        rd(A_COUNT, v); check("R8 load beats tick", v, 40);
    endtask

    task automatic t_div_change;
        logic [31:0] v;
        int p;
        setup(0, 100, 0);
        wr(A_COUNT, 20);
        wr(A_DIV, 1);
        rd(A_COUNT, v); check("R9 count kept", v, 20);
        wr(A_CTRL, 1);
        idle_count_irq(10, p);
        rd(A_COUNT, v); check("R9 new rate", v, 25);
    endtask

    task automatic t_evt_midrun;
        logic [31:0] v;
        int p;
        setup(0, 100, 0);
        wr(A_CTRL, 1);
        idle_count_irq(5, p);
        wr(A_EVT, 1);
        rd(A_COUNT, v); check("R7 event zeroes", v, 0);
        idle_count_irq(4, p);
        rd(A_COUNT, v); check("R7 runs after event", v, 4);
        rd(A_EVT, v); check("R7 event reads 0", v, 0);
    endtask

    task automatic t_hold;
        logic [31:0] a;
        logic [31:0] b;
        int p;
        wr(A_CTRL, 0);
        rd(A_COUNT, a);
        idle_count_irq(10, p);
        rd(A_COUNT, b); check("R2 hold while stopped", b, a);
    endtask

    task automatic t_storage;
        logic [31:0] v;
        logic [31:0] c;
        wr(A_MODEA, 32'h1234_5678);
        wr(A_MODEB, 32'h0BAD_F00D);
        wr(A_OPT, 32'h0000_00A5);
        for (int i = 0; i < 4; i++) wr(A_CMP0 + 8'(4 * i), 32'hC000_0000 + i);
        rd(A_MODEA, v); check("R10 modeA", v, 32'h1234_5678);
        rd(A_MODEB, v); check("R10 modeB", v, 32'h0BAD_F00D);
        rd(A_OPT, v);   check("R10 option", v, 32'h0000_00A5);
        for (int i = 0; i < 4; i++) begin
            rd(A_CMP0 + 8'(4 * i), v);
            check("R10 compare", v, 32'hC000_0000 + i);
        end
        rd(A_COUNT, c);
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd(A_HOLE, v);  check("R11 hole reads 0", v, 0);
        rd(A_CTRL, v);  check("R11 ctrl untouched", v, 0);
        rd(A_COUNT, v); check("R11 count untouched", v, c);
        rd(A_MODEA, v); check("R11 modeA untouched", v, 32'h1234_5678);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_rate();
        t_wrap_irq();
        t_status_and();
        t_irq_disabled();
        t_zero_limit();
        t_count_load();
        t_div_change();
        t_evt_midrun();
        t_hold();
        t_storage();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule